// File: doc/BRIEF.md
# Narrow-Bus DRAM Command Sequencer

This controller-side block turns one memory request into the cycle-by-cycle pin activity of a DRAM that has a very narrow command and address bus. Two control pins are time-shared. The first carries chip select and then row strobe. The second carries column strobe and then write enable. The 16-bit row and the 16-bit column each travel over eight address pins as a low half followed by a high half. Fixed gaps separate the row phase, the column phase and the 8-beat data burst on the 18-bit data bus.

A client offers a request on a valid/ready handshake. The request carries a direction flag, a row and a column. The sequencer lowers ready while the transaction occupies the command pins. It raises ready again in the last column cycle, so a new request can start its row phase while the previous burst is still waiting to run.

Read beats come out on `rd_data`, qualified by `rd_valid`. Write beats are taken from `wr_data`, paced by `wr_ready`. During every beat, two complementary strobe pairs change level so that the far end can find each beat by its transition.

Top module: `dram_cmd_seq`

## Requirements
- R1: After reset, and whenever no transaction is active, `req_ready` is 1. Both control pins are 0, `cmd_addr` is 0, `rd_valid`, `wr_ready` and `dq_oe` are 0, and the strobes hold their level. `strb_n` is always the bitwise inverse of `strb_p`.
- R2: In the first cycle after a request is accepted, `cmd_cs_ras`=1, `cmd_cas_we`=0 and `cmd_addr`=row[7:0]. In the second cycle, `cmd_cs_ras`=1, `cmd_cas_we`=0 and `cmd_addr`=row[15:8].
- R3: In cycles 2 to 9 after acceptance, both control pins and `cmd_addr` are 0.
- R4: In cycle 10 after acceptance, `cmd_cs_ras`=1, `cmd_cas_we`=1 and `cmd_addr`=col[7:0]. In cycle 11, `cmd_cs_ras`=0, `cmd_cas_we` equals the write flag (1 = write) and `cmd_addr`=col[15:8].
- R5: `req_ready` is 0 from cycle 0 through cycle 10 of a transaction and returns to 1 in cycle 11. A request held valid while ready is 0 is not taken and puts nothing on the pins.
- R6: For a read, `rd_valid` is 1 in exactly cycles 21 to 28 after acceptance, `rd_data` equals `dq_in` in those cycles, and `dq_oe` stays 0.
- R7: For a write, `wr_ready` and `dq_oe` are 1 in exactly cycles 21 to 28, and `dq_out` equals `wr_data` in those cycles. `rd_valid` and `wr_ready` are never 1 together.
- R8: Both bits of `strb_p` take a new level at the start of every beat, so the level in each beat cycle differs from the cycle before. Outside beats they do not change.
- R9: A request accepted in cycle 11 of a transaction starts its row phase 12 cycles after the previous one. Chained reads and writes each keep their own direction, and the bursts never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | 16 | Row address |
| req_col | input | 16 | Column address |
| cmd_cs_ras | output | 1 | Chip select, then row strobe |
| cmd_cas_we | output | 1 | Column strobe, then write enable |
| cmd_addr | output | 8 | Address half |
| dq_in | input | 18 | Data bus, inbound |
| dq_out | output | 18 | Data bus, outbound |
| dq_oe | output | 1 | Drive enable for the data bus |
| rd_data | output | 18 | Read beat |
| rd_valid | output | 1 | Read beat present |
| wr_data | input | 18 | Write beat |
| wr_ready | output | 1 | Write beat taken |
| strb_p | output | 2 | Reference strobes, true side |
| strb_n | output | 2 | Reference strobes, complement side |

## Verification
The hardest case to reach is a new request arriving in the one cycle where ready reopens while an earlier burst is still queued in the delay line. In that case the command pins and the data bus serve two different transactions at once. The stimulus offers each next request at the exact negative edge of cycle 11 of the one before, so a mixed read, read, write, read chain runs with no idle cycles between transactions. A scoreboard indexed by absolute cycle holds the expected beat windows, and the bench checks every cycle against it, including the strobe level. A separate case holds a stray request valid through the gap phase, to show that it is refused.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
   typedef enum logic {XFER_RD = 1'b0, XFER_WR = 1'b1} xfer_dir_e;

   typedef struct packed {
      logic      vld;
      xfer_dir_e dir;
   } beat_tok_t;
endpackage

// File: rtl/dram_cmd_phase.sv
module dram_cmd_phase
   import dram_seq_pkg::*;
#(
   parameter int ROW_W  = 16,
   parameter int COL_W  = 16,
   parameter int ADDR_W = 8,
   parameter int T_RCD  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   output logic              ctl_a,
   output logic              ctl_b,
   output logic [ADDR_W-1:0] addr,
   output beat_tok_t         tok
);
   localparam int LAST = T_RCD + 1;
   localparam int PW   = $clog2(LAST + 1);

   if (ROW_W != 2 * ADDR_W || COL_W != 2 * ADDR_W) begin : g_bad_split
      $error("address must split into two equal halves");
   end
   if (T_RCD < 3) begin : g_bad_rcd
      $error("row-to-column delay too short");
   end

   logic              busy;
   logic [PW-1:0]     ph;
   logic [ROW_W-1:0]  row_q;
   logic [COL_W-1:0]  col_q;
   xfer_dir_e         dir_q;
   logic              take;

   assign req_ready = !busy || (ph == PW'(LAST));
   assign take      = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         ph    <= '0;
         row_q <= '0;
         col_q <= '0;
         dir_q <= XFER_RD;
      end else if (take) begin
         busy  <= 1'b1;
         ph    <= '0;
         row_q <= req_row;
         col_q <= req_col;
         dir_q <= req_write ? XFER_WR : XFER_RD;
      end else if (busy) begin
         if (ph == PW'(LAST)) busy <= 1'b0;
         else                 ph   <= ph + 1'b1;
      end
   end

   always_comb begin
      ctl_a = 1'b0;
      ctl_b = 1'b0;
      addr  = '0;
      if (busy) begin
         if (ph == PW'(0)) begin
            ctl_a = 1'b1;
            addr  = row_q[ADDR_W-1:0];
         end else if (ph == PW'(1)) begin
            ctl_a = 1'b1;
            addr  = row_q[ROW_W-1:ADDR_W];
         end else if (ph == PW'(T_RCD)) begin
            ctl_a = 1'b1;
            ctl_b = 1'b1;
            addr  = col_q[ADDR_W-1:0];
         end else if (ph == PW'(LAST)) begin
            ctl_b = (dir_q == XFER_WR);
            addr  = col_q[COL_W-1:ADDR_W];
         end
      end
   end

   assign tok.vld = busy && (ph == PW'(LAST));
   assign tok.dir = dir_q;

   AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_a && !ctl_b && addr == row_q[ROW_W-1:ADDR_W] && ph == PW'(1)) |=> !ctl_a && !ctl_b); // R3
endmodule

// File: rtl/dram_beat_pipe.sv
module dram_beat_pipe
   import dram_seq_pkg::*;
#(
   parameter int DEPTH = 9
) (
   input  logic      clk,
   input  logic      rst_n,
   input  beat_tok_t tok_in,
   output beat_tok_t tok_out
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("pipe needs at least one stage");
   end

   if (DEPTH == 1) begin : g_single
      beat_tok_t st;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st <= '0;
         else        st <= tok_in;
      end
      assign tok_out = st;
   end else begin : g_chain
      beat_tok_t st [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) st[i] <= '0;
         end else begin
            st[0] <= tok_in;
            for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
         end
      end
      assign tok_out = st[DEPTH-1];
   end
endmodule

// File: rtl/dram_burst_eng.sv
module dram_burst_eng
   import dram_seq_pkg::*;
#(
   parameter int DATA_W = 18,
   parameter int BURST  = 8,
   parameter int NSTRB  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  beat_tok_t         tok,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   output logic [NSTRB-1:0]  strb_p,
   output logic [NSTRB-1:0]  strb_n
);
   localparam int LW = $clog2(BURST + 1);

   if (BURST < 2) begin : g_bad_burst
      $error("burst must have at least two beats");
   end

   logic          active;
   logic [LW-1:0] left;
   xfer_dir_e     dir;
   logic          strb_q;
   logic          flip;

   assign flip = tok.vld || (active && left > LW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         left   <= '0;
         dir    <= XFER_RD;
         strb_q <= 1'b0;
      end else begin
         if (flip) strb_q <= !strb_q;
         if (tok.vld) begin
            active <= 1'b1;
            left   <= LW'(BURST);
            dir    <= tok.dir;
         end else if (active) begin
            if (left == LW'(1)) active <= 1'b0;
            else                left   <= left - 1'b1;
         end
      end
   end

   assign rd_valid = active && (dir == XFER_RD);
   assign wr_ready = active && (dir == XFER_WR);
   assign dq_oe    = wr_ready;
   assign dq_out   = wr_ready ? wr_data : '0;
   assign rd_data  = rd_valid ? dq_in : '0;

   for (genvar g = 0; g < NSTRB; g++) begin : g_strb
      assign strb_p[g] = strb_q;
      assign strb_n[g] = !strb_q;
   end

   AST_STRB_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> strb_q != $past(strb_q)); // R8
   AST_STRB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!tok.vld && !active) |=> $stable(strb_q)); // R1
   AST_TOK_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      tok.vld |-> !active); // R9
endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
   import dram_seq_pkg::*;
#(
   parameter int ROW_W  = 16,
   parameter int COL_W  = 16,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 18,
   parameter int BURST  = 8,
   parameter int NSTRB  = 2,
   parameter int T_RCD  = 10,
   parameter int T_CL   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   output logic              cmd_cs_ras,
   output logic              cmd_cas_we,
   output logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] dq_in,
   output logic [DATA_W-1:0] dq_out,
   output logic              dq_oe,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   output logic [NSTRB-1:0]  strb_p,
   output logic [NSTRB-1:0]  strb_n
);
   localparam int PIPE_D = T_CL - 1;

   if (T_CL < 2) begin : g_bad_cl
      $error("column-to-data delay too short");
   end
   if (T_RCD + 2 < BURST) begin : g_bad_spacing
      $error("chained bursts would collide");
   end

   beat_tok_t tok_col, tok_beat;

   dram_cmd_phase #(
      .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .T_RCD(T_RCD)
   ) u_phase (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_row(req_row), .req_col(req_col),
      .ctl_a(cmd_cs_ras), .ctl_b(cmd_cas_we), .addr(cmd_addr),
      .tok(tok_col)
   );

   dram_beat_pipe #(.DEPTH(PIPE_D)) u_pipe (
      .clk(clk), .rst_n(rst_n), .tok_in(tok_col), .tok_out(tok_beat)
   );

   dram_burst_eng #(
      .DATA_W(DATA_W), .BURST(BURST), .NSTRB(NSTRB)
   ) u_burst (
      .clk(clk), .rst_n(rst_n), .tok(tok_beat),
      .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
      .rd_data(rd_data), .rd_valid(rd_valid),
      .wr_data(wr_data), .wr_ready(wr_ready),
      .strb_p(strb_p), .strb_n(strb_n)
   );

   AST_ROW_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> cmd_cs_ras && !cmd_cas_we
                                   && cmd_addr == $past(req_row[ADDR_W-1:0])); // R2
   AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid && wr_ready)); // R7
   AST_STRB_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      strb_n == ~strb_p); // R1
endmodule

// File: tb/dram_cmd_seq_bench.sv
module dram_cmd_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [15:0] req_row = '0;
   logic [15:0] req_col = '0;
   logic        cmd_cs_ras, cmd_cas_we;
   logic [7:0]  cmd_addr;
   logic [17:0] dq_in = '0;
   logic [17:0] dq_out;
   logic        dq_oe;
   logic [17:0] rd_data;
   logic        rd_valid;
   logic [17:0] wr_data = '0;
   logic        wr_ready;
   logic [1:0]  strb_p, strb_n;

   int  n_chk = 0;
   int  n_bad = 0;
   int  cyc = 0;
   bit  mon_on = 1'b0;
   bit  done = 1'b0;
   bit  exp_beat [64];
   bit  exp_wr [64];
   logic [1:0] prev_strb = '0;

   dram_cmd_seq u_dram_cmd_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_row(req_row), .req_col(req_col),
      .cmd_cs_ras(cmd_cs_ras), .cmd_cas_we(cmd_cas_we), .cmd_addr(cmd_addr),
      .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
      .rd_data(rd_data), .rd_valid(rd_valid),
      .wr_data(wr_data), .wr_ready(wr_ready),
      .strb_p(strb_p), .strb_n(strb_n)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      #1;
      dq_in   <= 18'(cyc * 37 + 5);
      wr_data <= 18'(cyc * 91 + 3);
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // data-side monitor: R6 R7 R8 every cycle
   always @(negedge clk) begin
      if (mon_on) begin
         bit b, w;
         b = exp_beat[cyc % 64];
         w = exp_wr[cyc % 64];
         check(rd_valid == (b && !w), "R6", "rd_valid", rd_valid, b && !w);
         check(wr_ready == (b && w), "R7", "wr_ready", wr_ready, b && w);
         check(dq_oe == (b && w), "R7", "dq_oe", dq_oe, b && w);
         if (b && !w) check(rd_data == dq_in, "R6", "rd_data", rd_data, dq_in);
         if (b && w)  check(dq_out == wr_data, "R7", "dq_out", dq_out, wr_data);
         if (b) check(strb_p == ~prev_strb, "R8", "strobe toggle", strb_p, ~prev_strb);
         else   check(strb_p == prev_strb, "R8", "strobe hold", strb_p, prev_strb);
         check(strb_n == ~strb_p, "R1", "strobe pair", strb_n, ~strb_p);
         exp_beat[cyc % 64] = 1'b0;
      end
      prev_strb = strb_p;
   end

   // caller is at a negedge; returns at the negedge of cycle 11
   task automatic issue(input bit wr, input logic [15:0] row, input logic [15:0] col,
                        input bit junk, input string req);
      int a;
      check(req_ready == 1'b1, req, "ready before offer", req_ready, 1);
      req_valid = 1'b1;
      req_write = wr;
      req_row   = row;
      req_col   = col;
      a = cyc + 1;
      for (int k = 21; k <= 28; k++) begin
         exp_beat[(a + k) % 64] = 1'b1;
         exp_wr[(a + k) % 64]   = wr;
      end
      @(posedge clk);
      #1;
      if (junk) begin
         req_row = 16'hFFFF;
         req_col = 16'hFFFF;
         req_write = !wr;
      end else begin
         req_valid = 1'b0;
      end
      for (int c = 0; c <= 11; c++) begin
         @(negedge clk);
         if (c == 0) begin
            check(cmd_cs_ras && !cmd_cas_we, "R2", "row lo ctl", {cmd_cs_ras, cmd_cas_we}, 2'b10);
            check(cmd_addr == row[7:0], "R2", "row lo addr", cmd_addr, row[7:0]);
         end else if (c == 1) begin
            check(cmd_cs_ras && !cmd_cas_we, "R2", "row hi ctl", {cmd_cs_ras, cmd_cas_we}, 2'b10);
            check(cmd_addr == row[15:8], "R2", "row hi addr", cmd_addr, row[15:8]);
         end else if (c < 10) begin
            check(!cmd_cs_ras && !cmd_cas_we && cmd_addr == 0, junk ? "R5" : "R3",
                  "gap pins", {cmd_cs_ras, cmd_cas_we, cmd_addr}, 0);
         end else if (c == 10) begin
            check(cmd_cs_ras && cmd_cas_we, "R4", "col lo ctl", {cmd_cs_ras, cmd_cas_we}, 2'b11);
            check(cmd_addr == col[7:0], "R4", "col lo addr", cmd_addr, col[7:0]);
         end else begin
            check(!cmd_cs_ras && cmd_cas_we == wr, "R4", "col hi ctl", {cmd_cs_ras, cmd_cas_we}, {1'b0, wr});
            check(cmd_addr == col[15:8], "R4", "col hi addr", cmd_addr, col[15:8]);
         end
         if (c <= 10) check(req_ready == 1'b0, "R5", "ready low", req_ready, 0);
         else         check(req_ready == 1'b1, "R5", "ready reopens", req_ready, 1);
         if (c == 10) req_valid = 1'b0;
      end
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check(!cmd_cs_ras && !cmd_cas_we && cmd_addr == 0, "R1", "idle pins",
               {cmd_cs_ras, cmd_cas_we, cmd_addr}, 0);
         check(req_ready == 1'b1, "R1", "idle ready", req_ready, 1);
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
      check(!cmd_cs_ras && !cmd_cas_we && cmd_addr == 0, "R1", "reset pins",
            {cmd_cs_ras, cmd_cas_we, cmd_addr}, 0);
      check(!rd_valid && !wr_ready && !dq_oe, "R1", "reset data", {rd_valid, wr_ready, dq_oe}, 0);
      check(strb_p == 2'b00 && strb_n == 2'b11, "R1", "reset strobes", {strb_p, strb_n}, 4'b0011);
      mon_on = 1'b1;
      idle_cycles(5);
   endtask

   task automatic t_read();
      issue(1'b0, 16'hA55A, 16'h3C96, 1'b0, "R6");
      idle_cycles(25);
   endtask

   task automatic t_write_junk();
      issue(1'b1, 16'h1234, 16'hFEDC, 1'b1, "R7");
      idle_cycles(25);
   endtask

   task automatic t_chain();
      issue(1'b0, 16'h0102, 16'h0304, 1'b0, "R9");
      issue(1'b0, 16'h8081, 16'h8283, 1'b0, "R9");
      issue(1'b1, 16'hC0DE, 16'hBEEF, 1'b0, "R9");
      issue(1'b0, 16'h7F00, 16'h00F7, 1'b0, "R9");
      idle_cycles(30);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_read();
      t_write_junk();
      t_chain();
      finish_run();
   end

   initial begin
      #(20 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end
endmodule